// File: doc/BRIEF.md
# Path Error Counter Accumulator

This block sits in the receive path of a switch port and forwards a stream of 32-bit words. Each frame is marked by a start flag on its first word and an end flag on its last word; the last word holds the frame check value. Most frames pass through unchanged. A diagnostic frame gathers error totals along a path, and the block recognises it by a command byte in its first payload word. In such a frame the block adds this port's own link error counts into the counter fields of the payload, so that the frame collects a total for every hop it crosses.

The port supplies one error total for each counter field. Each total is already summed over the parallel links that form this hop. The block divides each total by the link-group size before adding it, so a bundle of links gives a per-link average. The addition saturates and never wraps. When the port reports that it cannot do the update in hardware, the block leaves the counters alone and clears a capability bit in the frame. Any frame that the block recognises leaves with a freshly computed CRC-32 in its last word. Every word, modified or not, takes exactly one clock cycle to pass through.

Top module: `path_err_accum`

## Requirements
- R1: Every accepted word appears on the output exactly one clock cycle later, with its start and end flags intact. An idle input cycle gives an idle output cycle.
- R2: A frame is recognised only when word index 2 has 0xE7 in bits 31:24 and that word is not the frame's last word. The start word has index 0. Any other frame, including its last word, leaves bit-for-bit unchanged.
- R3: In a recognised frame with capability asserted, each word at indices 3 to 8 becomes that word plus floor(local total k / link count), where k = index - 3 selects a 32-bit slice of the local counter bus (slice k is bits 32k+31 down to 32k).
- R4: The addition in R3 saturates at 0xFFFFFFFF and never wraps around.
- R5: A link count from 1 to 8 is used as the divisor. A link count of 0 is treated as 1.
- R6: In a recognised frame with capability deasserted, the words at indices 3 to 8 pass unchanged and bit 0 of the word at index 9 is forced to 0. With capability asserted, the word at index 9 passes unchanged.
- R7: The last word of a recognised frame is replaced by a CRC-32. The CRC uses polynomial 0x04C11DB7 and starts at 0xFFFFFFFF. It takes in every earlier output word of the frame, one word per step, from bit 31 down to bit 0, with no bit reflection, and the final value is inverted.
- R8: After reset the output is idle.
- R9: Idle cycles inside a frame do not change its output words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is present |
| in_data | input | 32 | Input word |
| in_sof | input | 1 | First word of a frame |
| in_eof | input | 1 | Last word of a frame (carries the CRC) |
| hw_capable | input | 1 | Port can perform the update in hardware |
| link_count | input | 4 | Number of parallel links in this hop (0 means 1) |
| local_cnt | input | 192 | Six 32-bit local error totals, slice k at bits 32k+31:32k |
| out_valid | output | 1 | Output word is present |
| out_data | output | 32 | Output word |
| out_sof | output | 1 | First word of a frame |
| out_eof | output | 1 | Last word of a frame |

## Verification
Frames are sent with and without the command byte, so that any change made to a frame that should pass through stands out. A frame whose command word is also its last word checks the edge of the recognition rule. Recognised frames are run with link counts of 0, 1, 4 and 8 against known local totals, which tells a correct floor division apart from a raw sum or an off-by-one divisor. Counter fields near all-ones separate saturation from wraparound. Capability-off frames show that the counters are left alone while the flag bit is cleared. Short frames and frames with random idle gaps show that the CRC covers exactly the modified words that came before the last word.

// File: rtl/path_err_pkg.sv
package path_err_pkg;

    typedef logic [31:0] word_t;

    typedef struct packed {
        word_t data;
        logic  sof;
        logic  eof;
    } beat_t;

    localparam word_t CRC_POLY = 32'h04C1_1DB7;
    localparam word_t CRC_INIT = 32'hFFFF_FFFF;

    function automatic word_t crc32_step(input word_t crc_in, input word_t d);
        word_t r;
        logic  fb;
        r = crc_in;
        for (int i = 31; i >= 0; i--) begin
            fb = r[31] ^ d[i];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

    function automatic word_t sat_add(input word_t a, input word_t b);
        logic [32:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[32] ? 32'hFFFF_FFFF : s[31:0];
    endfunction

endpackage

// File: rtl/pea_frame_track.sv
module pea_frame_track #(
    parameter int       HDR_WORDS = 2,
    parameter int       IDX_W     = 8,
    parameter bit [7:0] CMD_CODE  = 8'hE7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic             sof,
    input  logic             eof,
    input  logic [7:0]       cmd_byte,
    output logic [IDX_W-1:0] cur_idx,
    output logic             match_now
);
    localparam logic [IDX_W-1:0] CMD_IDX = IDX_W'(HDR_WORDS);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic [IDX_W-1:0] idx_q;
    logic             match_q;

    assign cur_idx   = sof ? '0 : idx_q;
    assign match_now = sof ? 1'b0 : match_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            match_q <= 1'b0;
        end else if (valid) begin
            if (eof) begin
                idx_q   <= '0;
                match_q <= 1'b0;
            end else begin
                idx_q   <= (cur_idx == IDX_MAX) ? IDX_MAX : cur_idx + 1'b1;
                match_q <= match_now | ((cur_idx == CMD_IDX) && (cmd_byte == CMD_CODE));
            end
        end
    end

    // R9: idle cycles leave the position in the frame untouched
    a_r9_idx_hold: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(idx_q) && $stable(match_q));

endmodule

// File: rtl/pea_cnt_update.sv
module pea_cnt_update
    import path_err_pkg::*;
(
    input  word_t      field_in,
    input  word_t      local_sum,
    input  logic [3:0] link_count,
    output word_t      field_out
);
    logic [3:0] lc_eff;
    word_t      quot;

    assign lc_eff    = (link_count == 4'd0) ? 4'd1 : link_count;
    assign quot      = local_sum / {28'd0, lc_eff};
    assign field_out = sat_add(field_in, quot);

    always_comb begin
        if (!$isunknown({field_in, local_sum, link_count})) begin
            // R4: the result never falls below the carried value
            a_r4_no_wrap: assert (field_out >= field_in)
                else $error("R4 counter wrapped");
            // R5: quotient is the floor of sum over the effective link count
            a_r5_floor_lo: assert (({4'd0, quot} * 36'(lc_eff)) <= 36'(local_sum))
                else $error("R5 quotient too large");
            a_r5_floor_hi: assert ((({4'd0, quot} + 36'd1) * 36'(lc_eff)) > 36'(local_sum))
                else $error("R5 quotient too small");
        end
    end

endmodule

// File: rtl/pea_crc.sv
module pea_crc
    import path_err_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  valid,
    input  logic  sof,
    input  logic  eof,
    input  word_t word,
    output word_t crc_fin
);
    word_t crc_q;
    word_t crc_in;

    assign crc_in  = sof ? CRC_INIT : crc_q;
    assign crc_fin = ~crc_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= CRC_INIT;
        end else if (valid && !eof) begin
            crc_q <= crc32_step(crc_in, word);
        end
    end

    // R9: the running CRC does not move on idle cycles
    a_r9_crc_hold: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(crc_q));

endmodule

// File: rtl/path_err_accum.sv
module path_err_accum
    import path_err_pkg::*;
#(
    parameter int       HDR_WORDS = 2,
    parameter int       NUM_CNT   = 6,
    parameter int       IDX_W     = 8,
    parameter int       CAP_BIT   = 0,
    parameter bit [7:0] CMD_CODE  = 8'hE7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [31:0]           in_data,
    input  logic                  in_sof,
    input  logic                  in_eof,
    input  logic                  hw_capable,
    input  logic [3:0]            link_count,
    input  logic [NUM_CNT*32-1:0] local_cnt,
    output logic                  out_valid,
    output logic [31:0]           out_data,
    output logic                  out_sof,
    output logic                  out_eof
);
    localparam int SEL_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
    localparam logic [IDX_W-1:0] CNT_FIRST = IDX_W'(HDR_WORDS + 1);
    localparam logic [IDX_W-1:0] CNT_LAST  = IDX_W'(HDR_WORDS + NUM_CNT);
    localparam logic [IDX_W-1:0] FLAG_IDX  = IDX_W'(HDR_WORDS + NUM_CNT + 1);

    word_t loc [NUM_CNT];
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_unpack
        assign loc[g] = local_cnt[g*32 +: 32];
    end

    logic [IDX_W-1:0] cur_idx;
    logic             match_now;
    logic [IDX_W-1:0] rel_idx;
    logic [SEL_W-1:0] sel;
    logic             is_cnt;
    word_t            loc_sel;
    word_t            upd_word;
    word_t            mod_word;
    word_t            crc_fin;
    beat_t            out_q;
    logic             out_valid_q;

    pea_frame_track #(
        .HDR_WORDS (HDR_WORDS),
        .IDX_W     (IDX_W),
        .CMD_CODE  (CMD_CODE)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .valid     (in_valid),
        .sof       (in_sof),
        .eof       (in_eof),
        .cmd_byte  (in_data[31:24]),
        .cur_idx   (cur_idx),
        .match_now (match_now)
    );

    assign rel_idx = cur_idx - CNT_FIRST;
    assign sel     = rel_idx[SEL_W-1:0];
    assign is_cnt  = match_now && (cur_idx >= CNT_FIRST) && (cur_idx <= CNT_LAST);
    assign loc_sel = is_cnt ? loc[sel] : '0;

    pea_cnt_update u_upd (
        .field_in   (in_data),
        .local_sum  (loc_sel),
        .link_count (link_count),
        .field_out  (upd_word)
    );

    always_comb begin
        mod_word = in_data;
        if (in_eof) begin
            if (match_now) mod_word = crc_fin;
        end else if (is_cnt && hw_capable) begin
            mod_word = upd_word;
        end else if (match_now && (cur_idx == FLAG_IDX) && !hw_capable) begin
            mod_word[CAP_BIT] = 1'b0;
        end
    end

    pea_crc u_crc (
        .clk     (clk),
        .rst     (rst),
        .valid   (in_valid),
        .sof     (in_sof),
        .eof     (in_eof),
        .word    (mod_word),
        .crc_fin (crc_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_q <= 1'b0;
            out_q       <= '0;
        end else begin
            out_valid_q <= in_valid;
            out_q       <= '{data: mod_word, sof: in_sof & in_valid, eof: in_eof & in_valid};
        end
    end

    assign out_valid = out_valid_q;
    assign out_data  = out_q.data;
    assign out_sof   = out_q.sof;
    assign out_eof   = out_q.eof;

    // R1: fixed single-cycle delay for every word and every gap
    a_r1_valid_follow: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r1_idle_follow: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r1_marks: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_sof == $past(in_sof)) && (out_eof == $past(in_eof)));

    // R2: words of unrecognised frames go through unchanged
    a_r2_passthru: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !match_now) |=> (out_data == $past(in_data)));

    // R6: a port without hardware support clears the capability bit
    a_r6_cap_clear: assert property (@(posedge clk) disable iff (rst)
        (in_valid && match_now && !in_eof && (cur_idx == FLAG_IDX) && !hw_capable)
        |=> !out_data[CAP_BIT]);

endmodule

// File: tb/path_err_accum_bench.sv
module path_err_accum_bench;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid, in_sof, in_eof, hw_capable;
    logic [31:0]  in_data;
    logic [3:0]   link_count;
    logic [191:0] local_cnt;
    logic         out_valid, out_sof, out_eof;
    logic [31:0]  out_data;

    always #5 clk = ~clk;

    path_err_accum u_path_err_accum (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_sof     (in_sof),
        .in_eof     (in_eof),
        .hw_capable (hw_capable),
        .link_count (link_count),
        .local_cnt  (local_cnt),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_sof    (out_sof),
        .out_eof    (out_eof)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int r1_err = 0;
    bit done   = 0;
    logic vin_d = 1'b0;

    logic [31:0] loc_b [6];
    logic [31:0] got_d [$];
    bit          got_s [$];
    bit          got_e [$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) vin_d <= rst ? 1'b0 : in_valid;

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid !== vin_d) r1_err++;
            if (out_valid) begin
                got_d.push_back(out_data);
                got_s.push_back(out_sof);
                got_e.push_back(out_eof);
            end
        end
    end

    function automatic logic [31:0] b_crc(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 31; i >= 0; i--) begin
            if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ 32'h04C11DB7;
            else              r = {r[30:0], 1'b0};
        end
        return r;
    endfunction

    function automatic logic [31:0] b_sat(input logic [31:0] a, input logic [31:0] b);
        logic [32:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[32] ? 32'hFFFFFFFF : s[31:0];
    endfunction

    function automatic void model(input logic [31:0] fr[$], input bit cap, input int lc,
                                  output logic [31:0] ex[$]);
        bit          m;
        int          n;
        int          div;
        logic [31:0] c;
        logic [31:0] w;
        ex  = {};
        n   = fr.size();
        div = (lc == 0) ? 1 : lc;
        m   = (n > 3) && (fr[2][31:24] == 8'hE7);
        c   = 32'hFFFFFFFF;
        for (int i = 0; i < n - 1; i++) begin
            w = fr[i];
            if (m && cap && i >= 3 && i <= 8) w = b_sat(w, loc_b[i-3] / div);
            if (m && !cap && i == 9) w[0] = 1'b0;
            c = b_crc(c, w);
            ex.push_back(w);
        end
        ex.push_back(m ? ~c : fr[n-1]);
    endfunction

    function automatic string tag_of(input int i, input int n, input bit m);
        if (!m)             return "R2";
        if (i == n - 1)     return "R7";
        if (i >= 3 && i <= 8) return "R3";
        if (i == 9)         return "R6";
        return "R2";
    endfunction

    function automatic void mk(input bit m, input int len, output logic [31:0] fr[$]);
        fr = {};
        for (int i = 0; i < len; i++) fr.push_back($urandom);
        if (len > 2) begin
            if (m) fr[2][31:24] = 8'hE7;
            else if (fr[2][31:24] == 8'hE7) fr[2][31:24] = 8'h5A;
        end
        if (len > 9) fr[9][0] = 1'b1;
    endfunction

    task automatic idle();
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = $urandom;
    endtask

    task automatic send(input logic [31:0] fr[$], input int gap_pct);
        for (int i = 0; i < fr.size(); i++) begin
            while (($urandom % 100) < gap_pct) idle();
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_data  = fr[i];
            in_sof   = (i == 0);
            in_eof   = (i == fr.size() - 1);
        end
        idle();
    endtask

    task automatic run(input logic [31:0] fr[$], input bit cap, input int lc, input int gap_pct);
        logic [31:0] ex [$];
        bit m;
        m = (fr.size() > 3) && (fr[2][31:24] == 8'hE7);
        hw_capable = cap;
        link_count = 4'(lc);
        for (int k = 0; k < 6; k++) local_cnt[k*32 +: 32] = loc_b[k];
        got_d = {}; got_s = {}; got_e = {};
        send(fr, gap_pct);
        repeat (3) idle();
        model(fr, cap, lc, ex);
        chk(got_d.size() == ex.size(), "R1 length", 32'(got_d.size()), 32'(ex.size()));
        if (got_d.size() == ex.size()) begin
            chk(got_s[0] && got_e[ex.size()-1], "R1 markers", {31'd0, got_e[ex.size()-1]}, 32'd1);
            for (int i = 0; i < ex.size(); i++)
                chk(got_d[i] === ex[i], tag_of(i, ex.size(), m), got_d[i], ex[i]);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] fr [$];
        void'($urandom(32'd4242));
        rst = 1'b1; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = '0;
        hw_capable = 1'b1; link_count = 4'd1; local_cnt = '0;
        for (int k = 0; k < 6; k++) loc_b[k] = 32'd0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 reset idle", {31'd0, out_valid}, 32'd0);

        for (int k = 0; k < 6; k++) loc_b[k] = 32'd100 * (k + 1) + 7;

        // R2: no command code, and command code in last word
        mk(0, 12, fr); run(fr, 1, 1, 0);
        mk(1, 3, fr);  run(fr, 1, 1, 0);
        chk(got_d.size() == 3 && got_d[2] === fr[2], "R2 cmd on last word", got_d[2], fr[2]);

        // R3 / R7: capable, single link
        mk(1, 12, fr); run(fr, 1, 1, 0);

        // R5: divide by 4, 8 and the zero case
        mk(1, 12, fr); fr[4] = 32'd0; run(fr, 1, 4, 0);
        chk(got_d[4] == 32'd207 / 4, "R5 divide by 4", got_d[4], 32'd51);
        mk(1, 12, fr); fr[4] = 32'd0; run(fr, 1, 8, 0);
        chk(got_d[4] == 32'd25, "R5 divide by 8", got_d[4], 32'd25);
        mk(1, 12, fr); fr[4] = 32'd0; run(fr, 1, 0, 0);
        chk(got_d[4] == 32'd207, "R5 zero means one", got_d[4], 32'd207);

        // R4: saturation
        mk(1, 12, fr); fr[3] = 32'hFFFFFFF0; fr[4] = 32'hFFFFFFFF;
        loc_b[0] = 32'd100; loc_b[1] = 32'hFFFFFFFF;
        run(fr, 1, 1, 0);
        chk(got_d[3] == 32'hFFFFFFFF, "R4 saturate", got_d[3], 32'hFFFFFFFF);
        chk(got_d[4] == 32'hFFFFFFFF, "R4 saturate max", got_d[4], 32'hFFFFFFFF);

        // R6: no hardware support
        mk(1, 12, fr); run(fr, 0, 2, 0);
        chk(got_d[9][0] == 1'b0, "R6 flag cleared", got_d[9], fr[9] & ~32'd1);
        chk(got_d[5] == fr[5], "R6 counters untouched", got_d[5], fr[5]);
        mk(1, 12, fr); run(fr, 1, 2, 0);
        chk(got_d[9] == fr[9], "R6 flag kept", got_d[9], fr[9]);

        // R7: short recognised frame
        mk(1, 6, fr); run(fr, 1, 3, 0);

        // R9: random frames with idle gaps
        for (int t = 0; t < 40; t++) begin
            for (int k = 0; k < 6; k++) loc_b[k] = $urandom;
            mk(($urandom % 4) != 0, 3 + ($urandom % 12), fr);
            run(fr, ($urandom % 3) != 0, $urandom % 9, 30);
        end

        chk(r1_err == 0, "R1 valid timing", 32'(r1_err), 32'd0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule